// File: doc/BRIEF.md
# Serial Frame Transmitter with Break and Synchronous Clock

This block serialises 8-bit words onto a single line. Each frame is a low start bit, then the data bits with the least significant bit first, then a high stop period. The stop period can last half a bit, one bit, one and a half bits or two bits. All timing comes from a one-cycle enable pulse, `tick`, that the surrounding logic supplies at sixteen times the bit rate. One bit is therefore sixteen ticks and one half-bit is eight ticks, so the fractional stop lengths are exact.

A word is handed over with a valid/ready handshake. Ready is high only while the line is idle and no break is waiting. With line-bus mode enabled, a one-cycle break request holds the line low for thirteen bit times and then high for one bit time. A break requested during a frame waits until that frame's stop period has ended.

An optional clock output supports synchronous receivers. It gives exactly one pulse per data bit and no pulse during the start bit or the stop period. Its resting level and the bit half that carries the pulse can both be configured. When the clock output is disabled, the pin holds its resting level.

Top module: `uart_sync_tx`

## Requirements
- R1: After reset, and whenever no frame or break is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1 (unless a break is waiting), and `sclk` equals `cfg_cpol`.
- R2: An accepted word produces a start bit with `txd`=0, then data bits 0 through 7 in that order. Each of these bits lasts 16 ticks, and the start bit begins in the cycle after the handshake.
- R3: The stop period is high, and its length is taken from `cfg_stop` when the word is accepted: 2'b00 gives 16 ticks, 2'b01 gives 8, 2'b10 gives 32 and 2'b11 gives 24. `busy` falls when the stop period ends.
- R4: Bit timing advances only on cycles where `tick` is 1. While a frame is in progress and `tick` is 0, `txd` does not change.
- R5: `in_ready` is 1 only when the block is idle and no break is waiting. `busy` is 1 for the whole frame or break.
- R6: With `cfg_lin`=1, a one-cycle `brk_req` at idle sets a pending break. The line then goes low on the next cycle for 13×16 ticks, stays high for 16 ticks, and the block returns to idle.
- R7: With `cfg_lin`=0, `brk_req` has no effect: `txd` stays 1 and `busy` stays 0.
- R8: A break requested while a frame is in progress begins right after that frame's stop period ends, and `in_ready` stays 0 until the break has finished.
- R9: `sclk` differs from `cfg_cpol` only during data bits. It is at `cfg_cpol` throughout the start bit and the stop period.
- R10: With `cfg_clk_en`=1, `sclk` is inverted from `cfg_cpol` for ticks 8 to 15 of each data bit when `cfg_cpha`=0, and for ticks 0 to 7 when `cfg_cpha`=1.
- R11: With `cfg_clk_en`=0, `sclk` stays at `cfg_cpol` during the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at 16× bit rate |
| in_data | input | 8 | Word to send |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken |
| cfg_stop | input | 2 | Stop length code |
| cfg_lin | input | 1 | Enables break generation |
| cfg_clk_en | input | 1 | Enables clock output pulses |
| cfg_cpol | input | 1 | Resting level of `sclk` |
| cfg_cpha | input | 1 | 0: pulse in second half of bit, 1: in first half |
| brk_req | input | 1 | Break request pulse |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Synchronous clock output |
| busy | output | 1 | Frame or break in progress |

## Verification
Six words are sent, and together they cover all four stop codes, both clock polarities, both phases and the clock output switched on and off. Patterns such as 0xA5, 0x01 and 0x80 expose a reversed bit order or a shift by one bit. The measured stop length separates the four codes from one another. Sampling `sclk` in both halves of each bit separates the two phases, and also separates a disabled clock from one stuck at the wrong level. Further directed runs cover a break from idle, a break requested in the middle of a frame, a break request with line-bus mode off, and a slow `tick` that shows timing depends only on the enable.

// File: rtl/uart_sync_tx.sv
module uart_sync_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int BREAK_BITS    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_lin,
  input  logic              cfg_clk_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              brk_req,
  output logic              txd,
  output logic              sclk,
  output logic              busy
);
  localparam int HALF  = TICKS_PER_BIT / 2;
  localparam int CNT_W = $clog2(TICKS_PER_BIT * BREAK_BITS + 1);
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BRK, S_MARK} st_t;

  st_t               st;
  logic [CNT_W-1:0]  tc, seg_len, seg_last;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] sh;
  logic [1:0]        stop_r;
  logic [2:0]        halves;
  logic              pend, seg_end, go_brk;

  always_comb begin
    case (stop_r)
      2'b00:   halves = 3'd2;
      2'b01:   halves = 3'd1;
      2'b10:   halves = 3'd4;
      default: halves = 3'd3;
    endcase
    case (st)
      S_STOP:  seg_len = CNT_W'(HALF) * CNT_W'(halves);
      S_BRK:   seg_len = CNT_W'(TICKS_PER_BIT * BREAK_BITS);
      default: seg_len = CNT_W'(TICKS_PER_BIT);
    endcase
  end

  assign seg_last = seg_len - CNT_W'(1);
  assign seg_end  = tick && (st != S_IDLE) && (tc == seg_last);
  assign go_brk   = pend && ((st == S_IDLE) ||
                    (seg_end && (st == S_STOP || st == S_MARK)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tc     <= '0;
      bidx   <= '0;
      sh     <= '0;
      stop_r <= 2'b00;
      pend   <= 1'b0;
    end else begin
      pend <= (pend && !go_brk) || (cfg_lin && brk_req);
      if (st == S_IDLE) begin
        tc <= '0;
        if (pend) begin
          st <= S_BRK;
        end else if (in_valid) begin
          st     <= S_START;
          sh     <= in_data;
          stop_r <= cfg_stop;
          bidx   <= '0;
        end
      end else if (tick) begin
        if (!seg_end) begin
          tc <= tc + CNT_W'(1);
        end else begin
          tc <= '0;
          case (st)
            S_START: st <= S_DATA;
            S_DATA: begin
              sh <= {1'b0, sh[DATA_W-1:1]};
              if (bidx == IDX_W'(DATA_W - 1)) st <= S_STOP;
              else bidx <= bidx + IDX_W'(1);
            end
            S_BRK:   st <= S_MARK;
            default: st <= go_brk ? S_BRK : S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_START, S_BRK: txd = 1'b0;
      S_DATA:         txd = sh[0];
      default:        txd = 1'b1;
    endcase
  end

  assign sclk     = cfg_cpol ^ (cfg_clk_en && (st == S_DATA) &&
                    ((tc >= CNT_W'(HALF)) ^ cfg_cpha));
  assign busy     = (st != S_IDLE);
  assign in_ready = (st == S_IDLE) && !pend;
endmodule

module uart_sync_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic txd,
  input logic sclk,
  input logic busy,
  input logic in_ready,
  input logic cfg_cpol
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R5
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);
  // R4
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));
  // R9
  clock_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != cfg_cpol) |-> busy);
  // R2
  first_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

bind uart_sync_tx uart_sync_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .sclk(sclk),
  .busy(busy), .in_ready(in_ready), .cfg_cpol(cfg_cpol)
);

// File: tb/uart_sync_tx_bench.sv
`timescale 1ns/1ps
module uart_sync_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0, cfg_lin = 1'b0, cfg_clk_en = 1'b0;
  logic cfg_cpol = 1'b1, cfg_cpha = 1'b0, brk_req = 1'b0;
  logic [1:0] cfg_stop = 2'b00;
  logic in_ready, txd, sclk, busy;

  int total = 0, bad = 0, tick_div = 1, tick_cnt = 0;
  bit done = 0;
  logic tx_a [0:399];
  logic ck_a [0:399];
  logic bz_a [0:399];
  logic rd_a [0:399];

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div <= 1) tick = 1'b1;
    else begin
      tick_cnt = (tick_cnt + 1) % tick_div;
      tick = (tick_cnt == 0);
    end
  end

  uart_sync_tx u_uart_sync_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_stop(cfg_stop),
    .cfg_lin(cfg_lin), .cfg_clk_en(cfg_clk_en), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .brk_req(brk_req), .txd(txd), .sclk(sclk),
    .busy(busy)
  );

  // {data, stop code, cpol, cpha, clock enable}
  localparam logic [12:0] VEC [0:5] = '{
    {8'hA5, 2'b00, 1'b0, 1'b0, 1'b1},
    {8'h3C, 2'b01, 1'b1, 1'b0, 1'b1},
    {8'h01, 2'b10, 1'b0, 1'b1, 1'b1},
    {8'hFE, 2'b11, 1'b1, 1'b1, 1'b1},
    {8'h80, 2'b00, 1'b0, 1'b0, 1'b0},
    {8'h5A, 2'b11, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic start_frame(input logic [7:0] d, input logic [1:0] sc);
    in_data  = d;
    cfg_stop = sc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic capture(input int n, input int pulse_at);
    for (int c = 0; c < n; c++) begin
      tx_a[c] = txd; ck_a[c] = sclk; bz_a[c] = busy; rd_a[c] = in_ready;
      brk_req = (c == pulse_at);
      @(negedge clk);
    end
    brk_req = 1'b0;
  endtask

  function automatic int halves_of(input logic [1:0] sc);
    case (sc)
      2'b00: return 2;
      2'b01: return 1;
      2'b10: return 4;
      default: return 3;
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ready", in_ready, 1);
    chk("R1 reset sclk=cpol", sclk, 1);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      logic [1:0] sc;
      logic pol, pha, en;
      int h;
      {d, sc, pol, pha, en} = VEC[i];
      h = halves_of(sc);
      cfg_cpol = pol; cfg_cpha = pha; cfg_clk_en = en;
      @(negedge clk);
      chk("R1 idle sclk", sclk, pol);
      chk("R5 ready before frame", in_ready, 1);
      start_frame(d, sc);
      capture(200, -1);
      chk("R2 start bit", tx_a[8], 0);
      chk("R5 busy in frame", bz_a[60], 1);
      chk("R5 ready low in frame", rd_a[60], 0);
      chk("R9 sclk in start", ck_a[4], pol);
      for (int k = 0; k < 8; k++) begin
        chk("R2 data bit", tx_a[24 + 16*k], d[k]);
        chk(en ? "R10 sclk first half" : "R11 sclk first half",
            ck_a[20 + 16*k], pol ^ (en & pha));
        chk(en ? "R10 sclk second half" : "R11 sclk second half",
            ck_a[28 + 16*k], pol ^ (en & ~pha));
      end
      chk("R3 stop high", tx_a[144], 1);
      chk("R9 sclk in stop", ck_a[146], pol);
      chk("R3 stop last cycle busy", bz_a[144 + 8*h - 1], 1);
      chk("R3 idle after stop", bz_a[144 + 8*h], 0);
      chk("R1 ready after frame", rd_a[144 + 8*h], 1);
    end

    // R6: break from idle
    cfg_lin = 1'b1;
    capture(240, 0);
    begin
      int lows = 0;
      for (int c = 0; c < 240; c++) if (tx_a[c] === 1'b0) lows++;
      chk("R6 break low length", lows, 208);
    end
    chk("R6 line high before", tx_a[1], 1);
    chk("R6 break first low", tx_a[2], 0);
    chk("R6 break last low", tx_a[209], 0);
    chk("R6 mark after break", tx_a[210], 1);
    chk("R6 busy through mark", bz_a[225], 1);
    chk("R6 idle after mark", bz_a[226], 0);
    chk("R5 ready drops on request", rd_a[2], 0);

    // R7: break ignored when line-bus mode off
    cfg_lin = 1'b0;
    capture(40, 0);
    begin
      int hits = 0;
      for (int c = 0; c < 40; c++) if (tx_a[c] !== 1'b1 || bz_a[c] !== 1'b0) hits++;
      chk("R7 no effect", hits, 0);
    end

    // R8: break deferred past a frame
    cfg_lin = 1'b1; cfg_clk_en = 1'b0;
    start_frame(8'h33, 2'b01);
    capture(400, 50);
    cfg_lin = 1'b0;
    chk("R8 data still sent", tx_a[24], 1);
    chk("R8 stop kept", tx_a[151], 1);
    chk("R8 break after stop", tx_a[152], 0);
    chk("R8 break end", tx_a[359], 0);
    chk("R8 mark", tx_a[360], 1);
    chk("R8 ready held", rd_a[300], 0);
    chk("R8 idle at end", bz_a[376], 0);

    // R4: slow tick
    tick_div = 3;
    start_frame(8'hC3, 2'b00);
    begin
      int cnt = 0;
      while (busy && cnt < 700) begin
        if (cnt == 40) chk("R4 start bit stretched", txd, 0);
        @(negedge clk);
        cnt++;
      end
      chk("R4 frame length scaled", (cnt >= 478 && cnt <= 480), 1);
    end
    tick_div = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule